// File: doc/BRIEF.md
# Back-to-Back Serial Byte Receiver with Circular Store

This block receives asynchronous serial bytes (one low start bit, eight data bits least significant bit first, one high stop bit; the line rests high) at a fixed bit period counted in system clocks. The default is 80 clocks per bit. Bytes may follow one another with nothing between them but the single stop bit. The receiver therefore returns to hunting for a falling edge at the middle of the stop bit. That leaves half a bit of margin before the next start edge can arrive.

The line is resynchronised by a flop chain and then examined on every clock. A start is confirmed only if the line is still low half a bit after the falling edge. Each data bit is then sampled one full bit period after the one before, so the first data bit is taken one and a half bit periods after the edge. Each finished byte is written into a 16-entry circular store at the head index, and the head then advances. A consumer owns the tail index, which it presents at `tail_i`, and reads any slot through a combinational read port.

Top module: `burst_uart_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits with bit 0 first, and a stop bit. The assembled byte appears at `rd_data_o` when `rd_addr_i` selects the slot it was written to.
- R2: A falling edge starts a frame only if the line is still low half a bit period later. A low pulse of less than half a bit changes neither the head nor the flags.
- R3: The first data bit is sampled 1.5 bit periods after the start edge and each later bit one bit period after the previous one. Bytes sent at exactly the nominal rate are all received correctly.
- R4: Frames separated only by one stop bit are each captured, with no byte lost or merged.
- R5: Each stored byte goes to the slot at `head_o`. The head then increases by one modulo 16, wrapping from 15 to 0, and never moves by more than one per store.
- R6: If the stop-bit sample is low, `frame_err_o` sets and stays set until reset. The byte is still stored when space allows.
- R7: If advancing the head would make it equal to `tail_i`, the byte is dropped, the head holds, and `overrun_o` sets and stays set until reset.
- R8: After reset, `head_o` is 0 and both flags are 0.
- R9: When the consumer moves `tail_i` forward, the freed slots accept new bytes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_i | input | 1 | Serial line, rests high |
| tail_i | input | 4 | Consumer read index |
| rd_addr_i | input | 4 | Slot to read |
| head_o | output | 4 | Next slot to be written |
| rd_data_o | output | 8 | Contents of slot `rd_addr_i` |
| frame_err_o | output | 1 | Sticky flag: a stop bit was sampled low |
| overrun_o | output | 1 | Sticky flag: a byte was dropped because the store was full |

## Verification
The stop-bit check and the full-store check act on the same completed byte in the same cycle. A byte with a low stop bit that arrives when the store is full must raise both flags together and leave the head where it was. The bench sets this up after a fresh reset by presenting a tail one slot ahead of the head and then sending a byte with a bad stop bit. It then reads both flags and the head at the ports and compares them with its own model, which applies both rules to that byte independently.

// File: rtl/burst_rx_pkg.sv
package burst_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import burst_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 80,
  parameter int DATA_W       = 8,
  parameter bit STOP_CHECK   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              stop_bad_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     nbit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              line_q;
  logic              fall;

  assign fall = line_q & ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      nbit_q     <= '0;
      shreg_q    <= '0;
      line_q     <= 1'b1;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      stop_bad_o <= 1'b0;
    end else begin
      line_q     <= line_i;
      byte_vld_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_q  <= '0;
            nbit_q <= '0;
            // start must still be low at mid-bit, else treat as glitch
            state_q <= line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            nbit_q  <= nbit_q + 1'b1;
            shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
            if (nbit_q == LAST_BIT) begin
              if (STOP_CHECK) begin
                state_q <= ST_STOP;
              end else begin
                state_q    <= ST_IDLE;
                byte_o     <= {line_i, shreg_q[DATA_W-1:1]};
                stop_bad_o <= 1'b0;
                byte_vld_o <= 1'b1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == FULL_M1) begin
            // re-arm at mid stop bit: half a bit of slack before next start
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            byte_o     <= shreg_q;
            stop_bad_o <= ~line_i;
            byte_vld_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring.sv
module rx_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_vld_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     wr_stop_bad_i,
  input  logic [$clog2(DEPTH)-1:0] tail_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     frame_err_o,
  output logic                     overrun_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     head_nxt;
  logic              full;
  logic              do_wr;

  assign head_nxt = head_o + 1'b1;
  assign full     = (head_nxt == tail_i);
  assign do_wr    = wr_vld_i & ~full;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[head_o] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o      <= '0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (do_wr)                     head_o      <= head_nxt;
      if (wr_vld_i && full)          overrun_o   <= 1'b1;
      if (wr_vld_i && wr_stop_bad_i) frame_err_o <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/burst_uart_rx.sv
module burst_uart_rx #(
  parameter int CLKS_PER_BIT = 80,
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit STOP_CHECK   = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        serial_i,
  input  logic [3:0]  tail_i,
  input  logic [3:0]  rd_addr_i,
  output logic [3:0]  head_o,
  output logic [7:0]  rd_data_o,
  output logic        frame_err_o,
  output logic        overrun_o
);
  localparam int AW = $clog2(DEPTH);

  logic              line_s;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_d;
  logic              stop_bad;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (serial_i),
    .q_o    (line_s)
  );

  rx_framer #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DATA_W       (DATA_W),
    .STOP_CHECK   (STOP_CHECK)
  ) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_s),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .stop_bad_o (stop_bad)
  );

  rx_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_vld_i      (byte_vld),
    .wr_data_i     (byte_d),
    .wr_stop_bad_i (stop_bad),
    .tail_i        (tail_i[AW-1:0]),
    .rd_addr_i     (rd_addr_i[AW-1:0]),
    .head_o        (head_o[AW-1:0]),
    .rd_data_o     (rd_data_o[DATA_W-1:0]),
    .frame_err_o   (frame_err_o),
    .overrun_o     (overrun_o)
  );
endmodule

// File: rtl/burst_uart_rx_chk.sv
module burst_uart_rx_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] tail_i,
  input logic [AW-1:0] head_o,
  input logic          frame_err_o,
  input logic          overrun_o
);
  assert_head_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o != $past(head_o)) |-> (head_o == AW'($past(head_o) + 1'b1)));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o != $past(head_o)) |-> (head_o != $past(tail_i)));

  assert_drop_holds_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $stable(head_o));

  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overrun_o) |-> overrun_o);

  assert_ferr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_err_o) |-> frame_err_o);
endmodule

bind burst_uart_rx burst_uart_rx_chk #(.AW(4)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tail_i      (tail_i),
  .head_o      (head_o),
  .frame_err_o (frame_err_o),
  .overrun_o   (overrun_o)
);

// File: tb/burst_uart_rx_tb_top.sv
module burst_uart_rx_tb_top;
  localparam int BIT = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser = 1'b1;
  logic [3:0] tail = '0;
  logic [3:0] rd_addr = '0;
  logic [3:0] head;
  logic [7:0] rd_data;
  logic       ferr, ovr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [16];
  logic [3:0] m_head = '0;
  bit         m_ferr = 1'b0, m_ovr = 1'b0;

  always #4 clk = ~clk;

  burst_uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .serial_i(ser), .tail_i(tail),
    .rd_addr_i(rd_addr), .head_o(head), .rd_data_o(rd_data),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference store model (R5, R6, R7)
  task automatic model_push(input logic [7:0] b, input bit stop_ok);
    if (!stop_ok) m_ferr = 1'b1;
    if (4'(m_head + 1) == tail) m_ovr = 1'b1;
    else begin
      m_mem[m_head] = b;
      m_head = 4'(m_head + 1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    logic [9:0] fr;
    fr = {stop_ok, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      ser = fr[i];
      repeat (BIT) @(negedge clk);
    end
    model_push(b, stop_ok);
  endtask

  task automatic idle(input int n);
    ser = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ser = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_head = '0; m_ferr = 1'b0; m_ovr = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_slot(input logic [3:0] a, input string req);
    rd_addr = a;
    #1;
    chk(rd_data === m_mem[a], req, rd_data, m_mem[a]);
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(head === m_head, {req, " head"}, head, m_head);
    chk(ferr === m_ferr, {req, " frame_err"}, ferr, m_ferr);
    chk(ovr === m_ovr, {req, " overrun"}, ovr, m_ovr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int first;
    void'($urandom(32'h1d5e));
    @(negedge clk);
    do_reset();
    check_state("R8 reset");

    // R2: glitch shorter than half a bit
    ser = 1'b0;
    repeat (20) @(negedge clk);
    idle(300);
    check_state("R2 glitch");

    // R1 R3 R4: burst of 9 back-to-back bytes with 0x00 and 0xFF
    first = int'(m_head);
    for (int i = 0; i < 9; i++) begin
      b = (i == 2) ? 8'h00 : (i == 5) ? 8'hFF : 8'($urandom);
      send_byte(b, 1'b1);
    end
    idle(200);
    check_state("R4 burst1");
    for (int i = 0; i < 9; i++) check_slot(4'(first + i), "R1 R3 burst1 byte");

    // R9 R5: consumer frees space, 10-byte burst wraps head 15->0
    tail = 4'd9;
    first = int'(m_head);
    for (int i = 0; i < 10; i++) send_byte(8'($urandom), 1'b1);
    idle(200);
    check_state("R5 wrap");
    for (int i = 0; i < 10; i++) check_slot(4'(first + i), "R9 wrapped byte");

    // R6: bad stop bit, byte still stored, then a good byte
    first = int'(m_head);
    send_byte(8'hA5, 1'b0);
    idle(200);
    send_byte(8'h3C, 1'b1);
    idle(200);
    check_state("R6 framing");
    check_slot(4'(first), "R6 bad-stop byte");
    check_slot(4'(first + 1), "R6 following byte");

    // R7: fill to one short of tail, then drop
    first = int'(m_head);
    for (int i = 0; i < 5; i++) send_byte(8'($urandom), 1'b1);
    idle(200);
    check_state("R7 overrun");
    for (int i = 0; i < 3; i++) check_slot(4'(first + i), "R7 kept byte");

    // R9: moving tail admits new bytes again
    tail = 4'd12;
    first = int'(m_head);
    send_byte(8'h81, 1'b1);
    idle(200);
    check_state("R9 space freed");
    check_slot(4'(first), "R9 new byte");

    // R6 with R7 on the same byte: full store and bad stop together
    do_reset();
    tail = 4'd1;
    send_byte(8'h5A, 1'b0);
    idle(200);
    check_state("R6 R7 same byte");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule